// File: doc/BRIEF.md
# Two-Channel Voice Sample Output Unit

This unit holds two 12-bit voice samples written over a byte-wide register bus and drives them out of the chip in two forms. One form is a registered 12-bit word for an external digital-to-analog converter. The other is a single-bit pulse-width-modulated audio pin. Each sample is written as a pair of bytes. The upper byte carries sample bits 11..4, and the upper nibble of the lower byte carries bits 3..0.

Both outputs can run in separate mode or in mix mode, and each output has its own mode bit. In separate mode the converter word follows channel 0 and the pulse pin follows channel 1. In mix mode each output carries the truncated mean of the two channels. A periodic timer event strobe paces playback. Channel 1 is always captured on that strobe. Channel 0 is either passed through as soon as it is written, or held until the strobe. Each output has an enable. A disabled output rests at a quiet level.

Top module: `voice_out_unit`

## Requirements
- R1: Channel 0 sample bits 11..4 come from the byte written at offset 3, and bits 3..0 come from bits 7..4 of the byte at offset 2. Bits 3..0 of the offset-2 byte never affect any output.
- R2: Channel 1 is assembled the same way from offset 5 (bits 11..4) and bits 7..4 of offset 4. Bits 3..0 of the offset-4 byte do not enter the sample.
- R3: In the offset-4 byte, bit 0 selects mix (1) or separate (0) for the converter output, and bit 1 does the same for the pulse output. Both are separate after reset.
- R4: Bit 2 of the byte at offset 1 set to 1 selects direct transfer, which is the reset value. In direct transfer, with the converter enabled and in separate mode, a write to channel 0 appears on `dac_data` at the second rising edge after the write edge.
- R5: When bit 2 of offset 1 is 0, the converter's copy of channel 0 changes only at a clock edge where `tmr_evt` is high.
- R6: The copy of channel 1 used by the outputs is loaded only at edges where `tmr_evt` is high. In separate mode it alone sets the pulse duty.
- R7: In mix mode an output's source value is floor((ch0 + ch1) / 2) of the two captured samples, treated as unsigned. It never exceeds the larger of the two.
- R8: In the byte at offset 0, bit 7 enables the converter output and bit 6 enables the pulse output. Both are cleared by reset. A disabled converter output reads 0x800, and a disabled pulse output is low.
- R9: A free-running CNT_W-bit counter starts at 0 after reset. The pulse output is high, one cycle later, while the counter is below the upper CNT_W bits of the duty sample. A new duty value is taken only at the edge where the counter wraps from all ones.
- R10: A synchronous active-high reset puts `dac_data` at 0x800 and `pwm_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register offset |
| wr_data | input | 8 | Register write byte |
| tmr_evt | input | 1 | One-cycle timer event strobe |
| dac_data | output | 12 | Registered converter word |
| pwm_out | output | 1 | Registered pulse-width audio output |

## Verification
The bench builds the unit with CNT_W = 5, so one pulse period lasts 32 cycles. At that size many counter wraps, duty reloads and full-period duty counts fit into a short run. Because the duty is taken from the upper sample bits, the extreme samples 0x000 and 0xFFF still produce the never-high and nearly-always-high cases. ADDR_W stays at its default of 3, which covers the six register offsets.

// File: rtl/vo_pkg.sv
package vo_pkg;
  localparam int SAMP_W = 12;
  typedef logic [SAMP_W-1:0] samp_t;
  localparam samp_t MID_SCALE = samp_t'(1 << (SAMP_W - 1));

  localparam int OFS_ENA    = 0;
  localparam int OFS_XFER   = 1;
  localparam int OFS_CH0_LO = 2;
  localparam int OFS_CH0_HI = 3;
  localparam int OFS_CH1_LO = 4;
  localparam int OFS_CH1_HI = 5;

  localparam int BIT_DAC_EN  = 7;
  localparam int BIT_PWM_EN  = 6;
  localparam int BIT_DIRECT  = 2;
  localparam int BIT_DAC_MIX = 0;
  localparam int BIT_PWM_MIX = 1;
endpackage

// File: rtl/vo_regs.sv
module vo_regs
  import vo_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output samp_t             ch0_buf,
  output samp_t             ch1_buf,
  output logic              dac_mix,
  output logic              pwm_mix,
  output logic              ch0_direct,
  output logic              dac_en,
  output logic              pwm_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ch0_buf    <= '0;
      ch1_buf    <= '0;
      dac_mix    <= 1'b0;
      pwm_mix    <= 1'b0;
      ch0_direct <= 1'b1;
      dac_en     <= 1'b0;
      pwm_en     <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(OFS_ENA)) begin
        dac_en <= wr_data[BIT_DAC_EN];
        pwm_en <= wr_data[BIT_PWM_EN];
      end
      if (wr_addr == ADDR_W'(OFS_XFER))
        ch0_direct <= wr_data[BIT_DIRECT];
      if (wr_addr == ADDR_W'(OFS_CH0_LO))
        ch0_buf[3:0] <= wr_data[7:4];
      if (wr_addr == ADDR_W'(OFS_CH0_HI))
        ch0_buf[SAMP_W-1:4] <= wr_data;
      if (wr_addr == ADDR_W'(OFS_CH1_LO)) begin
        ch1_buf[3:0] <= wr_data[7:4];
        dac_mix      <= wr_data[BIT_DAC_MIX];
        pwm_mix      <= wr_data[BIT_PWM_MIX];
      end
      if (wr_addr == ADDR_W'(OFS_CH1_HI))
        ch1_buf[SAMP_W-1:4] <= wr_data;
    end
  end
endmodule

// File: rtl/vo_route.sv
module vo_route
  import vo_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tmr_evt,
  input  samp_t ch0_buf,
  input  samp_t ch1_buf,
  input  logic  ch0_direct,
  input  logic  dac_mix,
  input  logic  pwm_mix,
  input  logic  dac_en,
  output samp_t dac_data,
  output samp_t pwm_target
);
  samp_t          ch0_lat, ch1_lat;
  logic [SAMP_W:0] sum;
  samp_t          avg;

  assign sum        = {1'b0, ch0_lat} + {1'b0, ch1_lat};
  assign avg        = sum[SAMP_W:1];
  assign pwm_target = pwm_mix ? avg : ch1_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch0_lat  <= '0;
      ch1_lat  <= '0;
      dac_data <= MID_SCALE;
    end else begin
      if (ch0_direct || tmr_evt) ch0_lat <= ch0_buf;
      if (tmr_evt)               ch1_lat <= ch1_buf;
      if (!dac_en)      dac_data <= MID_SCALE;
      else if (dac_mix) dac_data <= avg;
      else              dac_data <= ch0_lat;
    end
  end

  // R5: deferred channel 0 holds between timer events
  p_ch0_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ch0_direct && !tmr_evt) |=> $stable(ch0_lat));
  // R6: channel 1 capture only on timer events
  p_ch1_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tmr_evt |=> $stable(ch1_lat));
  // R7: mixed word bounded by the larger captured sample
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (dac_en && dac_mix) |=>
      (dac_data <= (($past(ch0_lat) > $past(ch1_lat)) ? $past(ch0_lat) : $past(ch1_lat))));
  // R8: disabled converter rests at mid-scale
  p_dac_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !dac_en |=> dac_data == MID_SCALE);
endmodule

// File: rtl/vo_pwm.sv
module vo_pwm
  import vo_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pwm_en,
  input  samp_t target,
  output logic  pwm_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, duty;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      duty    <= '0;
      pwm_out <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      if (cnt == CNT_MAX) duty <= target[SAMP_W-1 -: CNT_W];
      pwm_out <= pwm_en && (cnt < duty);
    end
  end

  // R9: duty reloads only at counter wrap
  p_duty_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_MAX) |=> $stable(duty));
  // R9: counter advances by one each cycle
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + 1'b1);
  // R8: disabled pulse pin stays low
  p_pwm_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !pwm_out);
endmodule

// File: rtl/voice_out_unit.sv
module voice_out_unit
  import vo_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tmr_evt,
  output logic [11:0]       dac_data,
  output logic              pwm_out
);
  samp_t ch0_buf, ch1_buf, pwm_target, dac_word;
  logic  dac_mix, pwm_mix, ch0_direct, dac_en, pwm_en;

  vo_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ch0_buf(ch0_buf), .ch1_buf(ch1_buf), .dac_mix(dac_mix), .pwm_mix(pwm_mix),
    .ch0_direct(ch0_direct), .dac_en(dac_en), .pwm_en(pwm_en)
  );

  vo_route u_route (
    .clk(clk), .rst(rst), .tmr_evt(tmr_evt), .ch0_buf(ch0_buf), .ch1_buf(ch1_buf),
    .ch0_direct(ch0_direct), .dac_mix(dac_mix), .pwm_mix(pwm_mix), .dac_en(dac_en),
    .dac_data(dac_word), .pwm_target(pwm_target)
  );

  vo_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst(rst), .pwm_en(pwm_en), .target(pwm_target), .pwm_out(pwm_out)
  );

  assign dac_data = dac_word;

  // R10: reset state at the outputs
  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (dac_data == 12'h800) && !pwm_out);
endmodule

// File: tb/voice_out_unit_tb.sv
module voice_out_unit_tb;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 5;
  localparam int PERIOD = 1 << CNT_W;
  localparam int LIMIT  = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              tmr_evt = 1'b0;
  logic [11:0]       dac_data;
  logic              pwm_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  voice_out_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_evt(tmr_evt), .dac_data(dac_data), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_b0, m_b1, m_l0, m_l1, m_dmix, m_pmix, m_dir, m_den, m_pen;
  int m_cnt, m_duty, m_dac, m_pwm;

  always @(posedge clk) begin
    int tgt;
    if (rst) begin
      m_b0 <= 0; m_b1 <= 0; m_l0 <= 0; m_l1 <= 0; m_dmix <= 0; m_pmix <= 0;
      m_dir <= 1; m_den <= 0; m_pen <= 0; m_cnt <= 0; m_duty <= 0;
      m_dac <= 'h800; m_pwm <= 0;
    end else begin
      if (wr_en) begin
        case (int'(wr_addr))
          0: begin m_den <= wr_data[7]; m_pen <= wr_data[6]; end
          1: m_dir <= wr_data[2];
          2: m_b0 <= (m_b0 & 'hFF0) | int'(wr_data[7:4]);
          3: m_b0 <= (m_b0 & 'h00F) | (int'(wr_data) << 4);
          4: begin
               m_b1 <= (m_b1 & 'hFF0) | int'(wr_data[7:4]);
               m_dmix <= wr_data[0]; m_pmix <= wr_data[1];
             end
          5: m_b1 <= (m_b1 & 'h00F) | (int'(wr_data) << 4);
          default: ;
        endcase
      end
      if (m_dir != 0 || tmr_evt) m_l0 <= m_b0;
      if (tmr_evt) m_l1 <= m_b1;
      m_dac <= (m_den == 0) ? 'h800 : ((m_dmix != 0) ? (m_l0 + m_l1) / 2 : m_l0);
      tgt = (m_pmix != 0) ? (m_l0 + m_l1) / 2 : m_l1;
      if (m_cnt == PERIOD - 1) m_duty <= tgt >> (12 - CNT_W);
      m_pwm <= (m_pen != 0 && m_cnt < m_duty) ? 1 : 0;
      m_cnt <= (m_cnt + 1) % PERIOD;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 R5 R7 R8 dac vs model", int'(dac_data), m_dac);
      check("R6 R9 pwm vs model", int'(pwm_out), m_pwm);
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cycles, LIMIT);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic evt();
    @(negedge clk);
    tmr_evt = 1'b1;
    @(negedge clk);
    tmr_evt = 1'b0;
  endtask

  task automatic count_high(input string tag, input int exp);
    int hi = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    check(tag, hi, exp);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset dac", int'(dac_data), 'h800);
    check("R10 reset pwm", int'(pwm_out), 0);

    // still disabled: writes do not reach the outputs
    wr(3, 'h12); idle(4);
    check("R8 dac disabled mid-scale", int'(dac_data), 'h800);

    wr(0, 'hC0);
    // R1 with junk in the low nibble, direct transfer (R4)
    wr(3, 'hAB); wr(2, 'h5F);
    idle(2);
    check("R4 R1 direct ch0", int'(dac_data), 'hAB5);
    wr(2, 'h50); idle(3);
    check("R1 low nibble bits ignored", int'(dac_data), 'hAB5);

    // R2 R6: channel 1 captured only on event, drives PWM in separate mode
    wr(5, 'h50); wr(4, 'h0C);
    idle(PERIOD * 2);
    count_high("R6 no event yet, duty 0", 0);
    evt();
    idle(PERIOD * 2);
    count_high("R6 R9 R2 duty from ch1 0x500", 'h500 >> (12 - CNT_W));

    // R9 extremes
    wr(5, 'hFF); wr(4, 'hF0); evt(); idle(PERIOD * 2);
    count_high("R9 full-scale duty", PERIOD - 1);
    wr(5, 'h00); wr(4, 'h00); evt(); idle(PERIOD * 2);
    count_high("R9 zero duty", 0);

    // R5 deferred ch0
    wr(1, 'h00);
    wr(3, 'h34); wr(2, 'h60); idle(5);
    check("R5 deferred hold", int'(dac_data), 'hAB5);
    evt(); idle(2);
    check("R5 deferred update on event", int'(dac_data), 'h346);

    // R3 R7 mix modes
    wr(3, 'hFF); wr(2, 'hF0); wr(5, 'hFF); wr(4, 'hF1); evt(); idle(3);
    check("R7 R3 mix full scale", int'(dac_data), 'hFFF);
    wr(5, 'h00); wr(4, 'h13); evt(); idle(3);
    check("R7 mix floor avg", int'(dac_data), ('hFFF + 1) / 2);
    idle(PERIOD * 2);
    count_high("R3 R7 PWM mix duty", (('hFFF + 1) / 2) >> (12 - CNT_W));
    wr(4, 'h10); idle(3);
    check("R3 DAC back to separate", int'(dac_data), 'hFFF);

    // R8 disable
    wr(0, 'h00); idle(3);
    check("R8 dac disabled", int'(dac_data), 'h800);
    count_high("R8 pwm disabled", 0);

    // direct transfer again, mid-run reset
    wr(1, 'h04); wr(0, 'h80); wr(3, 'h77); idle(3);
    check("R4 direct restored", int'(dac_data), 'h770 | 'hF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reset dac again", int'(dac_data), 'h800);
    check("R10 reset pwm again", int'(pwm_out), 0);
    idle(4);
    finish_run();
  end
endmodule